// File: doc/BRIEF.md
# Supervised Alarm Latch

This block is a synchronous alarm controller for a safety panel. A hazard sensor line sets a sticky alarm lamp output, and the lamp stays lit after the sensor falls back to its safe level. An operator can turn the lamp off only by pressing the clear button while a supervisor key is turned and the hazard has gone away. A danger that has been seen therefore stays visible until someone with authority acknowledges it.

All inputs are sampled on the rising clock edge, and both outputs are registered. A set request and a clear request may arrive in the same cycle, and every input combination is legal: a set request always wins over a clear request. An enable line freezes the stored alarm while it is low. A one-cycle status pulse tells the panel that a clear attempt was refused. A refusal happens when the key was not turned or the hazard was still present.

Top module: `supervised_alarm_latch`

## Requirements
- R1: A cycle in which enable and hazard are both 1 makes alarm_o read 1 after the next rising edge. A hazard lasting a single clock cycle is enough to do this.
- R2: Once alarm_o is 1, it stays 1 after hazard returns to 0, for as long as no qualifying clear occurs.
- R3: alarm_o goes to 0 after the next edge only when enable, clear button and supervisor key are all 1 and hazard is 0 in the same sampled cycle.
- R4: When hazard, clear button and supervisor key are all 1 with enable 1, alarm_o is 1 after the edge. The set wins.
- R5: While enable is 0, alarm_o keeps its stored value whatever hazard, button and key do, and clear_refused_o stays 0.
- R6: clear_refused_o is 1 for exactly the cycle after a sampled cycle in which enable and button are 1 and either the key is 0 or hazard is 1. In every other case it is 0.
- R7: A synchronous active-low reset (rst_n = 0 at an edge) forces alarm_o and clear_refused_o to 0, whatever the other inputs are.
- R8: alarm_o never rises from 0 to 1 unless the previous sampled cycle had enable and hazard both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| hazard_i | input | 1 | Hazard sensor indication, 1 = danger |
| clear_btn_i | input | 1 | Operator clear button, 1 = pressed |
| sup_key_i | input | 1 | Supervisor authorization key, 1 = turned |
| enable_i | input | 1 | 1 = accept set and clear decisions, 0 = hold |
| alarm_o | output | 1 | Alarm lamp, 1 = lit |
| clear_refused_o | output | 1 | One-cycle pulse: the last clear attempt was refused |

## Verification
The bound checker checks the following on every cycle, as relations between sampled inputs and the next output values: setting, set priority, qualified clearing, hold under disable, no spurious rise, the refusal pulse and reset. Some behaviour is only shown by the bench's scenarios. One case is that a single-cycle hazard leaves the lamp lit many cycles later. Another is that reset wins while the lamp is lit and a refused clear is being requested at the same time. The bench also runs an exhaustive sweep of every input combination from both stored states, followed by a long random sequence, all compared against an arithmetic model.

// File: rtl/alarm_pkg.sv
// Package: shared decision type and the priority function used by the
// supervised alarm latch. Assumes all inputs are already synchronous.
package alarm_pkg;

    // Decision taken for the stored alarm bit in one cycle.
    typedef enum logic [1:0] {
        ALM_HOLD  = 2'd0,
        ALM_SET   = 2'd1,
        ALM_CLEAR = 2'd2
    } alarm_cmd_e;

    // Priority resolution: disabled -> hold, hazard -> set, qualified clear -> clear.
    function automatic alarm_cmd_e resolve_cmd(
        input logic en,
        input logic hazard,
        input logic clear_ok
    );
        if (!en)
            return ALM_HOLD;
        else if (hazard)
            return ALM_SET;
        else if (clear_ok)
            return ALM_CLEAR;
        else
            return ALM_HOLD;
    endfunction

endpackage

// File: rtl/alarm_req_decode.sv
// Module: alarm_req_decode
// Combinational front end. It turns the raw panel inputs into a single
// resolved command and a refusal flag. Assumes the inputs are synchronous
// to the clock of the register stage that consumes its outputs.
module alarm_req_decode
    import alarm_pkg::*;
(
    input  logic       hazard_i,
    input  logic       clear_btn_i,
    input  logic       sup_key_i,
    input  logic       enable_i,
    output alarm_cmd_e cmd_o,
    output logic       refuse_o
);

    logic clear_authorised;

    // Authorisation term: button and key together, hazard checked by the priority stage.
    always_comb begin
        clear_authorised = clear_btn_i & sup_key_i;
    end

    // Priority resolution of set against clear.
    always_comb begin
        cmd_o = resolve_cmd(enable_i, hazard_i, clear_authorised);
    end

    // A refused attempt: button pressed while the key is missing or danger persists.
    always_comb begin
        refuse_o = enable_i & clear_btn_i & (~sup_key_i | hazard_i);
    end

endmodule

// File: rtl/alarm_state_reg.sv
// Module: alarm_state_reg
// Register stage. It holds the alarm bit and the refusal pulse. Applies a
// synchronous active-low reset. Assumes cmd_i is one of the three legal codes.
module alarm_state_reg
    import alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  alarm_cmd_e cmd_i,
    input  logic       refuse_i,
    output logic       alarm_q,
    output logic       refuse_q
);

    logic alarm_d;

    // Next-state selection for the sticky alarm bit.
    always_comb begin
        unique case (cmd_i)
            ALM_SET:   alarm_d = 1'b1;
            ALM_CLEAR: alarm_d = 1'b0;
            default:   alarm_d = alarm_q;
        endcase
    end

    // State update with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q  <= 1'b0;
            refuse_q <= 1'b0;
        end else begin
            alarm_q  <= alarm_d;
            refuse_q <= refuse_i;
        end
    end

endmodule

// File: rtl/supervised_alarm_latch.sv
// Module: supervised_alarm_latch (top)
// A sticky alarm that a hazard sets and that only a supervised operator
// clear can reset, once the hazard has gone. Set beats clear. Enable
// freezes the state. Assumes synchronous, debounced inputs.
module supervised_alarm_latch
    import alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard_i,
    input  logic clear_btn_i,
    input  logic sup_key_i,
    input  logic enable_i,
    output logic alarm_o,
    output logic clear_refused_o
);

    alarm_cmd_e cmd;
    logic       refuse_req;

    alarm_req_decode u_decode (
        .hazard_i    (hazard_i),
        .clear_btn_i (clear_btn_i),
        .sup_key_i   (sup_key_i),
        .enable_i    (enable_i),
        .cmd_o       (cmd),
        .refuse_o    (refuse_req)
    );

    alarm_state_reg u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_i    (cmd),
        .refuse_i (refuse_req),
        .alarm_q  (alarm_o),
        .refuse_q (clear_refused_o)
    );

endmodule

// File: rtl/alarm_latch_checker.sv
// Module: alarm_latch_checker
// Port-level temporal checks for supervised_alarm_latch. Attached through bind.
module alarm_latch_checker (
    input logic clk,
    input logic rst_n,
    input logic hazard_i,
    input logic clear_btn_i,
    input logic sup_key_i,
    input logic enable_i,
    input logic alarm_o,
    input logic clear_refused_o
);

    assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && hazard_i) |=> alarm_o);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_o && !(enable_i && clear_btn_i && sup_key_i && !hazard_i)) |=> alarm_o);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && clear_btn_i && sup_key_i && !hazard_i) |=> !alarm_o);

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && hazard_i && clear_btn_i && sup_key_i) |=> alarm_o);

    assert_disabled_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> ($stable(alarm_o) && !clear_refused_o));

    assert_refuse_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && clear_btn_i && (!sup_key_i || hazard_i)) |=> clear_refused_o);

    assert_refuse_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(enable_i && clear_btn_i && (!sup_key_i || hazard_i)) |=> !clear_refused_o);

    assert_reset_R7: assert property (@(posedge clk)
        !rst_n |=> (!alarm_o && !clear_refused_o));

    assert_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_o && !(enable_i && hazard_i)) |=> !alarm_o);

endmodule

bind supervised_alarm_latch alarm_latch_checker u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .hazard_i        (hazard_i),
    .clear_btn_i     (clear_btn_i),
    .sup_key_i       (sup_key_i),
    .enable_i        (enable_i),
    .alarm_o         (alarm_o),
    .clear_refused_o (clear_refused_o)
);

// File: tb/supervised_alarm_latch_tb.sv
// Bench: exhaustive input sweep from both stored states, plus a reset
// scenario and a random run, all compared against an arithmetic model.
module supervised_alarm_latch_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hazard = 1'b0, btn = 1'b0, key = 1'b0, en = 1'b0;
    logic alarm, refused;
    logic exp_alarm = 1'b0, exp_ref = 1'b0;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    supervised_alarm_latch u_dut (
        .clk (clk), .rst_n (rst_n), .hazard_i (hazard), .clear_btn_i (btn),
        .sup_key_i (key), .enable_i (en), .alarm_o (alarm), .clear_refused_o (refused)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b (h=%0b b=%0b k=%0b e=%0b)",
                     tag, act, exp, hazard, btn, key, en);
        end
    endtask

    function automatic string alarm_tag(input logic h, input logic b, input logic k,
                                        input logic e, input logic prev);
        if (!e)            return "R5";
        else if (h && b && k) return "R4";
        else if (h)        return "R1";
        else if (b && k)   return "R3";
        else if (!prev)    return "R8";
        else               return "R2";
    endfunction

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic step(input logic h, input logic b, input logic k, input logic e,
                        input logic r);
        logic prev;
        prev = exp_alarm;
        hazard = h; btn = b; key = k; en = e; rst_n = r;
        @(negedge clk);
        if (!r) begin
            exp_alarm = 1'b0; exp_ref = 1'b0;
        end else begin
            exp_ref = e & b & (~k | h);
            if (e && h)           exp_alarm = 1'b1;
            else if (e && b && k) exp_alarm = 1'b0;
        end
        check(alarm, exp_alarm, r ? alarm_tag(h, b, k, e, prev) : "R7");
        check(refused, exp_ref, r ? "R6" : "R7");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(0, 0, 0, 0, 0);                     // R7 reset state
        step(0, 0, 0, 1, 1);
        // R1: single-cycle hazard pulse latches; R2: holds afterwards
        step(1, 0, 0, 1, 1);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 1);
        // R6: button alone is refused, alarm stays
        step(0, 1, 0, 1, 1);
        // Exhaustive sweep from both stored states
        for (int st = 0; st < 2; st++) begin
            for (int c = 0; c < 16; c++) begin
                if (st == 1) step(1, 0, 0, 1, 1);
                else         step(0, 1, 1, 1, 1);
                step(c[3], c[2], c[1], c[0], 1);
                step(0, 0, 0, 1, 1);             // R2/R8 afterwards: effect persisted
            end
        end
        // R5: hazard while disabled must not set; clear while disabled must not clear
        step(0, 1, 1, 1, 1);
        step(1, 1, 0, 0, 1);
        step(0, 0, 0, 1, 1);
        step(1, 0, 0, 1, 1);
        step(0, 1, 1, 0, 1);
        step(0, 0, 0, 1, 1);
        // R7: reset wins over lit alarm and a refused-clear request
        step(1, 1, 0, 1, 0);
        step(0, 0, 0, 1, 1);
        // Random run against the model
        for (int n = 0; n < 400; n++) begin
            logic [4:0] v;
            v = 5'($urandom);
            step(v[0] & v[1], v[2], v[3], v[4] | v[1], ($urandom % 50) != 0);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule